// File: doc/BRIEF.md
# Bus-Master Memory Cycle Engine

This block runs byte-wide memory cycles on an external parallel bus with a 19-bit address and an 8-bit data path, after some other agent has handed it the bus. A client issues one request that names the operation, the start address, the byte count and a constant byte. The engine then runs the whole transfer without further help. A read streams each byte out on a valid pulse. A write asks for each byte with a one-cycle data request. A fill writes the constant byte to every address in the range.

Every transfer of one or more bytes pulls the active-low memory-request strobe low once. It keeps that strobe low over all the bytes and steps the address by one per byte. The active-low read and write strobes pulse for a fixed, parameterised number of cycles. Arbitration is not part of the block. A single ownership input says whether the bus is held. Without it, the address, strobes and data are released. When it returns, the strobes sit high for one cycle before their enables come back.

Top module: `memcyc_engine`

## Requirements
- R1: Byte i of a transfer that starts at address A is strobed with addr_o equal to (A + i) modulo 2^19, so the address wraps from 0x7FFFF to 0.
- R2: Each write byte is strobed with mreq_n low, data_oe high and data_o carrying the byte. wr_n is low for exactly WR_WIDTH consecutive cycles.
- R3: Each read byte holds rd_n low for exactly RD_WIDTH cycles. data_i is sampled in the last low cycle. rd_data carries the byte, with rd_valid high for the one cycle after rd_n rises.
- R4: A transfer of length N >= 1 pulls mreq_n low exactly once, gives exactly N strobe pulses, and then pulses done for one cycle after mreq_n has gone high again.
- R5: For op code 2'b01 (write), wr_req is high for one cycle before each byte's strobe, N times in all. The value on wr_data in that cycle is the value the byte writes.
- R6: For op codes 2'b10 and 2'b11 (fill), every byte writes req_fill as captured at acceptance, and wr_req stays low. Op code 2'b00 is a read.
- R7: A request with length 0 raises done in the cycle after acceptance, with no strobe activity.
- R8: While bus_owned is low, addr_oe, strobe_oe and data_oe are low and req_ready is low, so no request is accepted.
- R9: When bus_owned rises, strobe_oe stays low for one cycle while mreq_n, rd_n and wr_n are high, and turns on in the next cycle.
- R10: Dropping bus_owned during a transfer turns off all output enables in the same cycle and abandons the transfer without done. From the next cycle the strobes are high.
- R11: The strobe widths RD_WIDTH and WR_WIDTH are parameters. A value below 1 is taken as 1.
- R12: rd_n and wr_n are never low together, and neither is low while mreq_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_owned | input | 1 | High while the bus is granted to this block |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and owning the bus; request accepted when both valid and ready |
| req_op | input | 2 | 00 read, 01 write, 1x fill |
| req_addr | input | 19 | Start address |
| req_len | input | 8 | Byte count |
| req_fill | input | 8 | Constant byte for fill |
| wr_req | output | 1 | Write data request, data taken in the same cycle |
| wr_data | input | 8 | Write data for the current request |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle completion pulse |
| addr_o | output | 19 | Address bus value |
| addr_oe | output | 1 | Address output enable |
| mreq_n | output | 1 | Memory request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| strobe_oe | output | 1 | Output enable of the three strobes |
| data_o | output | 8 | Data bus value when driving |
| data_i | input | 8 | Data bus value when reading |
| data_oe | output | 1 | Data bus drive enable |

## Verification
The assertions check the strobe rules on every cycle: the read and write strobes never overlap and never fire outside memory-request. They also check that enables come back only after a cycle of high strobes, that an ownership loss clears the strobes and done, that a zero-length request finishes at once, and that read data arrives right after its strobe. The bench's sweeps over operation, length and start address are what show the rest: correct per-byte addresses across the 19-bit wrap, exact strobe widths, a single memory-request per burst, the data-request order, and a fill carrying only its constant.

// File: rtl/memcyc_pkg.sv
package memcyc_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_FILL  = 2'b10,
        OP_FILL2 = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_MREQ,
        ST_STRB,
        ST_GAP,
        ST_LOAD,
        ST_END
    } st_e;

    typedef struct packed {
        logic mreq_n;
        logic rd_n;
        logic wr_n;
    } strobes_t;

    localparam strobes_t STROBES_IDLE = '{mreq_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};

    function automatic int clamp1(input int w);
        return (w < 1) ? 1 : w;
    endfunction

    function automatic logic op_writes(input op_e op);
        return op != OP_READ;
    endfunction

    function automatic logic op_pulls(input op_e op);
        return op == OP_WRITE;
    endfunction

endpackage

// File: rtl/memcyc_addr.sv
module memcyc_addr #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/memcyc_ctrl.sv
module memcyc_ctrl
    import memcyc_pkg::*;
#(
    parameter int LEN_W    = 8,
    parameter int DATA_W   = 8,
    parameter int RD_WIDTH = 3,
    parameter int WR_WIDTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_fill,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] data_i,
    output logic              req_ready,
    output logic              addr_load,
    output logic              addr_step,
    output strobes_t          strb,
    output logic              drive,
    output logic [DATA_W-1:0] data_q,
    output logic              wr_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              done
);
    localparam int RD_CYC = clamp1(RD_WIDTH);
    localparam int WR_CYC = clamp1(WR_WIDTH);
    localparam int MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int CW = $clog2(MAX_CYC + 1);

    st_e              state;
    op_e              op_q;
    logic [LEN_W-1:0] rem_q;
    logic [CW-1:0]    cnt_q;
    logic             more;

    assign more      = rem_q > LEN_W'(1);
    assign req_ready = (state == ST_IDLE) && en;
    assign addr_load = req_valid && req_ready;
    assign addr_step = en && (state == ST_GAP) && more;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            op_q     <= OP_READ;
            rem_q    <= '0;
            cnt_q    <= '0;
            data_q   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (!en) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: if (req_valid) begin
                        op_q   <= op_e'(req_op);
                        rem_q  <= req_len;
                        data_q <= req_fill;
                        state  <= (req_len == '0) ? ST_END : ST_ADDR;
                    end
                    ST_ADDR: begin
                        if (op_pulls(op_q)) data_q <= wr_data;
                        state <= ST_MREQ;
                    end
                    ST_MREQ, ST_LOAD: begin
                        cnt_q <= op_writes(op_q) ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);
                        state <= ST_STRB;
                    end
                    ST_STRB: begin
                        if (cnt_q == '0) begin
                            if (!op_writes(op_q)) begin
                                rd_data  <= data_i;
                                rd_valid <= 1'b1;
                            end
                            state <= ST_GAP;
                        end else begin
                            cnt_q <= cnt_q - CW'(1);
                        end
                    end
                    ST_GAP: begin
                        if (more) begin
                            if (op_pulls(op_q)) data_q <= wr_data;
                            rem_q <= rem_q - LEN_W'(1);
                            state <= ST_LOAD;
                        end else begin
                            state <= ST_END;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    logic in_cycle;
    assign in_cycle = (state == ST_MREQ) || (state == ST_STRB) ||
                      (state == ST_GAP)  || (state == ST_LOAD);

    always_comb begin
        strb        = STROBES_IDLE;
        strb.mreq_n = !in_cycle;
        strb.rd_n   = !((state == ST_STRB) && !op_writes(op_q));
        strb.wr_n   = !((state == ST_STRB) && op_writes(op_q));
    end

    assign drive  = in_cycle && op_writes(op_q);
    assign wr_req = en && op_pulls(op_q) &&
                    ((state == ST_ADDR) || ((state == ST_GAP) && more));
    assign done   = (state == ST_END);

    // R12
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(!strb.rd_n && !strb.wr_n));

    // R12
    strobe_in_mreq_chk: assert property (@(posedge clk) disable iff (rst)
        (!strb.rd_n || !strb.wr_n) |-> !strb.mreq_n);

    // R7
    zero_len_done_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_load && req_len == '0) |=> (done && strb.mreq_n));

    // R10
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (strb.mreq_n && strb.rd_n && strb.wr_n && !done));

    // R3
    rd_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (strb.rd_n && $past(!strb.rd_n)));
endmodule

// File: rtl/memcyc_pads.sv
module memcyc_pads
    import memcyc_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_owned,
    input  strobes_t          strb,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              drive,
    output logic              en,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_oe,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              strobe_oe,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe
);
    logic own_q;

    always_ff @(posedge clk) begin
        if (rst) own_q <= 1'b0;
        else     own_q <= bus_owned;
    end

    assign en        = own_q && bus_owned;
    assign addr_oe   = en;
    assign strobe_oe = en;
    assign addr_o    = addr_in;
    assign mreq_n    = strb.mreq_n;
    assign rd_n      = strb.rd_n;
    assign wr_n      = strb.wr_n;
    assign data_o    = data_in;
    assign data_oe   = en && drive;

    // R9
    grant_high_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_oe) |-> ($past(strb.mreq_n) && $past(strb.rd_n) && $past(strb.wr_n)));
endmodule

// File: rtl/memcyc_engine.sv
module memcyc_engine
    import memcyc_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int LEN_W    = 8,
    parameter int RD_WIDTH = 3,
    parameter int WR_WIDTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_owned,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_fill,
    output logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_oe,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              strobe_oe,
    output logic [DATA_W-1:0] data_o,
    input  logic [DATA_W-1:0] data_i,
    output logic              data_oe
);
    logic              en;
    logic              addr_load;
    logic              addr_step;
    logic [ADDR_W-1:0] addr_q;
    strobes_t          strb;
    logic              drive;
    logic [DATA_W-1:0] data_q;

    memcyc_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (addr_load),
        .load_addr (req_addr),
        .step      (addr_step),
        .addr_q    (addr_q)
    );

    memcyc_ctrl #(
        .LEN_W    (LEN_W),
        .DATA_W   (DATA_W),
        .RD_WIDTH (RD_WIDTH),
        .WR_WIDTH (WR_WIDTH)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_len   (req_len),
        .req_fill  (req_fill),
        .wr_data   (wr_data),
        .data_i    (data_i),
        .req_ready (req_ready),
        .addr_load (addr_load),
        .addr_step (addr_step),
        .strb      (strb),
        .drive     (drive),
        .data_q    (data_q),
        .wr_req    (wr_req),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .done      (done)
    );

    memcyc_pads #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pads (
        .clk       (clk),
        .rst       (rst),
        .bus_owned (bus_owned),
        .strb      (strb),
        .addr_in   (addr_q),
        .data_in   (data_q),
        .drive     (drive),
        .en        (en),
        .addr_o    (addr_o),
        .addr_oe   (addr_oe),
        .mreq_n    (mreq_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .strobe_oe (strobe_oe),
        .data_o    (data_o),
        .data_oe   (data_oe)
    );
endmodule

// File: tb/memcyc_engine_bench.sv
module memcyc_engine_bench;
    localparam int RDW = 3;
    localparam int WRW = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_owned = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [7:0]  req_fill = '0;
    logic        wr_req;
    logic [7:0]  wr_data;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        done;
    logic [18:0] addr_o;
    logic        addr_oe, mreq_n, rd_n, wr_n, strobe_oe, data_oe;
    logic [7:0]  data_o;
    logic [7:0]  data_i;

    memcyc_engine #(.RD_WIDTH(RDW), .WR_WIDTH(WRW)) u_memcyc_engine (
        .clk(clk), .rst(rst), .bus_owned(bus_owned),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .req_fill(req_fill),
        .wr_req(wr_req), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .addr_o(addr_o), .addr_oe(addr_oe), .mreq_n(mreq_n),
        .rd_n(rd_n), .wr_n(wr_n), .strobe_oe(strobe_oe), .data_o(data_o),
        .data_i(data_i), .data_oe(data_oe)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    function automatic logic [7:0] mem_val(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {a[18:16], 5'h15};
    endfunction

    function automatic logic [7:0] wdat(input logic [18:0] s, input int i);
        return 8'(s[7:0] + 8'(i * 7) + 8'h31);
    endfunction

    assign data_i = mem_val(addr_o);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor state
    logic [1:0]  t_op = 2'b00;
    logic [18:0] t_start = '0;
    logic [7:0]  t_fill = '0;
    int wl = 0, rl = 0, nbytes = 0, wr_idx = 0, rv_idx = 0;
    int mreq_falls = 0, done_cnt = 0, viol = 0;
    logic p_mreq = 1'b1, p_wr = 1'b1, p_rd = 1'b1;

    always @(negedge clk) begin
        cycles++;
        if (rst) begin
            wr_data = '0;
        end else begin
            if (wr_req) begin
                wr_data = wdat(t_start, wr_idx);
                wr_idx++;
            end
            if (p_mreq && !mreq_n) mreq_falls++;
            if (done) done_cnt++;
            if ((!rd_n && !wr_n) || ((!rd_n || !wr_n) && mreq_n)) viol++;
            if (!wr_n) begin
                if (wl == 0) begin
                    chk(addr_o == 19'(t_start + 19'(nbytes)), "R1 write addr", addr_o, 19'(t_start + 19'(nbytes)));
                    chk(data_oe && !mreq_n && strobe_oe, "R2 write bus state", {data_oe, mreq_n}, 2'b10);
                    if (t_op[1])
                        chk(data_o == t_fill, "R6 fill data", data_o, t_fill);
                    else
                        chk(data_o == wdat(t_start, nbytes), "R5 write data", data_o, wdat(t_start, nbytes));
                end
                wl++;
            end else if (!p_wr) begin
                chk(wl == WRW, "R2 R11 wr width", wl, WRW);
                wl = 0;
                nbytes++;
            end
            if (!rd_n) begin
                if (rl == 0) begin
                    chk(addr_o == 19'(t_start + 19'(nbytes)), "R1 read addr", addr_o, 19'(t_start + 19'(nbytes)));
                    chk(!data_oe, "R3 data bus input", data_oe, 0);
                end
                rl++;
            end else if (!p_rd) begin
                chk(rl == RDW, "R3 R11 rd width", rl, RDW);
                rl = 0;
                nbytes++;
            end
            if (rd_valid) begin
                chk(rd_data == mem_val(19'(t_start + 19'(rv_idx))), "R3 read data",
                    rd_data, mem_val(19'(t_start + 19'(rv_idx))));
                rv_idx++;
            end
            p_mreq = mreq_n;
            p_wr   = wr_n;
            p_rd   = rd_n;
        end
    end

    task automatic clear_mon();
        wl = 0; rl = 0; nbytes = 0; wr_idx = 0; rv_idx = 0;
        mreq_falls = 0; done_cnt = 0; viol = 0;
    endtask

    task automatic run(input logic [1:0] op, input logic [18:0] a, input int len, input logic [7:0] fill);
        int guard;
        @(negedge clk);
        clear_mon();
        t_op = op; t_start = a; t_fill = fill;
        guard = 0;
        while (!req_ready && guard < 20) begin @(negedge clk); guard++; end
        req_valid = 1'b1; req_op = op; req_addr = a; req_len = 8'(len); req_fill = fill;
        @(negedge clk);
        req_valid = 1'b0;
        req_fill = ~fill;
        if (len == 0) begin
            // R7: done in the cycle after the accepting edge
            chk(done == 1'b1, "R7 zero length done", done, 1);
            chk(mreq_n && rd_n && wr_n, "R7 no bus activity", {mreq_n, rd_n, wr_n}, 3'b111);
        end
        guard = 0;
        while (done_cnt == 0 && guard < 600) begin @(negedge clk); guard++; end
        repeat (2) @(negedge clk);
        chk(done_cnt == 1, "R4 single done", done_cnt, 1);
        chk(mreq_falls == ((len > 0) ? 1 : 0), "R4 one mreq per transfer", mreq_falls, (len > 0) ? 1 : 0);
        chk(nbytes == len, "R4 strobe count", nbytes, len);
        chk(wr_idx == ((op == 2'b01) ? len : 0), "R5 R6 data requests", wr_idx, (op == 2'b01) ? len : 0);
        chk(rv_idx == ((op == 2'b00) ? len : 0), "R3 read bytes", rv_idx, (op == 2'b00) ? len : 0);
        chk(viol == 0, "R12 strobe rules", viol, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state and no ownership
        chk(!addr_oe && !strobe_oe && !data_oe, "R8 reset enables", {addr_oe, strobe_oe, data_oe}, 0);
        chk(!req_ready && !done, "R8 reset ready/done", {req_ready, done}, 0);
        req_valid = 1'b1; req_op = 2'b01; req_len = 8'd3;
        repeat (4) @(negedge clk);
        chk(!req_ready && !strobe_oe && done_cnt == 0 && mreq_n, "R8 request ignored unowned",
            {req_ready, strobe_oe}, 0);
        req_valid = 1'b0;
        // R9: grant sequence
        bus_owned = 1'b1;
        #1;
        chk(!strobe_oe && mreq_n && rd_n && wr_n, "R9 strobes high before enable", strobe_oe, 0);
        @(negedge clk);
        chk(strobe_oe && addr_oe && mreq_n && rd_n && wr_n, "R9 enable after one cycle", strobe_oe, 1);
        chk(done_cnt == 0, "R8 ignored request left no done", done_cnt, 0);

        // sweep
        for (int o = 0; o < 4; o++) begin
            for (int li = 0; li < 5; li++) begin
                for (int ai = 0; ai < 3; ai++) begin
                    int len;
                    logic [18:0] a;
                    len = (li == 4) ? 5 : li;
                    a = (ai == 0) ? 19'h0 : (ai == 1) ? 19'h123FF : 19'h7FFFE;
                    run(2'(o), a, len, 8'(8'h5A + o * 16 + li));
                end
            end
        end

        // R10: abort a write burst after the second data request
        @(negedge clk);
        clear_mon();
        t_op = 2'b01; t_start = 19'h00400;
        req_valid = 1'b1; req_op = 2'b01; req_addr = 19'h00400; req_len = 8'd10;
        @(negedge clk);
        req_valid = 1'b0;
        begin
            int g;
            g = 0;
            while (wr_idx < 2 && g < 100) begin @(negedge clk); g++; end
        end
        bus_owned = 1'b0;
        #1;
        chk(!strobe_oe && !addr_oe && !data_oe, "R10 enables off at once", {strobe_oe, addr_oe, data_oe}, 0);
        @(negedge clk);
        chk(mreq_n && rd_n && wr_n, "R10 strobes high after abort", {mreq_n, rd_n, wr_n}, 3'b111);
        bus_owned = 1'b1;
        repeat (3) @(negedge clk);
        chk(done_cnt == 0, "R10 abandoned without done", done_cnt, 0);
        chk(req_ready && mreq_n, "R10 idle after regrant", req_ready, 1);
        run(2'b00, 19'h7FFFF, 3, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        while (cycles < 150000) @(negedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule